// File: doc/BRIEF.md
# Opcode-Selected Arithmetic and Logic Unit

This block combines two unsigned operand words under a 3-bit operation code and returns one result word along with two status bits. Its eight operations are addition, subtraction, a pass-through of either operand, and four bitwise functions: AND, OR, XOR, and inversion of the first operand. The word width comes only from the `WIDTH` parameter. No operand or result width is fixed anywhere in the logic.

The datapath from operands to the next result is combinational. That datapath is a shared add/subtract unit with one extra bit, a per-bit logic slice, and a final selector. The result, carry and zero outputs are captured in flip-flops on the rising clock edge. A value presented before an edge therefore appears on the outputs after that edge and holds until the next one.

The carry bit has one meaning per operation. For addition it is the carry out of the widened sum. For subtraction it is the borrow, set when the first operand is below the second. For every other code it is 0. The zero bit tracks the result word for all codes.

Top module: `opsel_alu`

## Requirements
- R1: All operand and result ports are `WIDTH` bits wide, and every operation is correct for any `WIDTH` of 1 or more.
- R2: Code 3'b000 gives result = (a + b) mod 2^WIDTH, with carry equal to bit WIDTH of the (WIDTH+1)-bit sum.
- R3: Code 3'b001 gives result = (a - b) mod 2^WIDTH, with carry = 1 exactly when a < b as unsigned numbers (borrow).
- R4: Code 3'b010 gives result = a and code 3'b011 gives result = b, each with carry = 0.
- R5: Code 3'b100 gives a AND b, code 3'b101 gives a OR b, and code 3'b110 gives a XOR b, each bitwise, with carry = 0.
- R6: Code 3'b111 gives the bitwise inverse of a with carry = 0, and the value of b has no effect on any output.
- R7: For every code, zero is 1 exactly when every bit of result is 0.
- R8: The outputs change only at a rising clock edge. They show the operation on the inputs sampled at the most recent edge and do not follow input changes between edges.
- R9: While rst is high at a rising edge, the edge loads result = 0, carry = 0 and zero = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand (unsigned) |
| op_b | input | WIDTH | Second operand (unsigned) |
| op_sel | input | 3 | Operation code |
| result | output | WIDTH | Registered result word |
| carry | output | 1 | Registered carry (add) or borrow (subtract); 0 for other codes |
| zero | output | 1 | Registered flag, high when result is all zeros |

## Verification
The bench builds two copies of the block side by side, one with WIDTH = 3 and one with WIDTH = 8. The 3-bit copy is small enough that every combination of code, a and b (512 cases) is run, so every carry, borrow and zero corner is covered exhaustively. The 8-bit copy takes pseudo-random operands plus hand-picked extremes: all-ones plus one, zero minus one, equal operands, and complementary patterns. These show that nothing in the design depends on one particular width.

// File: rtl/opsel_alu_pkg.sv
`timescale 1ns/1ps
package opsel_alu_pkg;

  // Operation codes; the numeric values are the external encoding.
  typedef enum logic [2:0] {
    OP_ADD   = 3'b000,
    OP_SUB   = 3'b001,
    OP_PASSA = 3'b010,
    OP_PASSB = 3'b011,
    OP_AND   = 3'b100,
    OP_OR    = 3'b101,
    OP_XOR   = 3'b110,
    OP_NOTA  = 3'b111
  } alu_op_e;

  // Selector for the bitwise slice, taken from the low two code bits.
  typedef enum logic [1:0] {
    BW_AND = 2'b00,
    BW_OR  = 2'b01,
    BW_XOR = 2'b10,
    BW_INV = 2'b11
  } bw_fn_e;

endpackage

// File: rtl/opsel_alu_arith.sv
`timescale 1ns/1ps
module opsel_alu_arith #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] a_ext;
  logic [EXT_W-1:0] b_ext;
  logic [EXT_W-1:0] wide;

  assign a_ext = {1'b0, a};
  assign b_ext = {1'b0, b};

  // One widened adder/subtractor: the top bit is carry on add, borrow on subtract.
  always_comb begin
    if (do_sub) wide = a_ext - b_ext;
    else        wide = a_ext + b_ext;
  end

  assign sum  = wide[WIDTH-1:0];
  assign cout = wide[EXT_W-1];

endmodule

// File: rtl/opsel_alu_bitwise.sv
`timescale 1ns/1ps
module opsel_alu_bitwise
  import opsel_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       fn,
  output logic [WIDTH-1:0] y
);

  logic sel_and, sel_or, sel_xor;

  assign sel_and = (fn == BW_AND);
  assign sel_or  = (fn == BW_OR);
  assign sel_xor = (fn == BW_XOR);

  // One four-way slice per bit position.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y[i] = sel_and ? (a[i] & b[i]) :
                  sel_or  ? (a[i] | b[i]) :
                  sel_xor ? (a[i] ^ b[i]) :
                            ~a[i];
  end

endmodule

// File: rtl/opsel_alu.sv
`timescale 1ns/1ps
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry,
  output logic             zero
);

  alu_op_e          op;
  logic [WIDTH-1:0] arith_y;
  logic             arith_c;
  logic [WIDTH-1:0] logic_y;
  logic [WIDTH-1:0] nxt_res;
  logic             nxt_carry;

  assign op = alu_op_e'(op_sel);

  opsel_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a      (op_a),
    .b      (op_b),
    .do_sub (op == OP_SUB),
    .sum    (arith_y),
    .cout   (arith_c)
  );

  opsel_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a  (op_a),
    .b  (op_b),
    .fn (op_sel[1:0]),
    .y  (logic_y)
  );

  // Final selector: every path assigns both outputs.
  always_comb begin
    nxt_res   = logic_y;
    nxt_carry = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        nxt_res   = arith_y;
        nxt_carry = arith_c;
      end
      OP_PASSA: nxt_res = op_a;
      OP_PASSB: nxt_res = op_b;
      default:  nxt_res = logic_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      carry  <= 1'b0;
      zero   <= 1'b1;
    end else begin
      result <= nxt_res;
      carry  <= nxt_carry;
      zero   <= ~|nxt_res;
    end
  end

  // ---------------- assertions ----------------
  p_add_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b000) |=>
      ({carry, result} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));

  p_sub_borrow_r3: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b001) |=> (carry == ($past(op_a) < $past(op_b))));

  p_pass_a_r4: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b010) |=> (result == $past(op_a)));

  p_logic_no_carry_r5: assert property (@(posedge clk) disable iff (rst)
    (op_sel[2] || op_sel[1]) |=> !carry);

  p_invert_r6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b111) |=> (result == ~$past(op_a)));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0));

  p_reset_load_r9: assert property (@(posedge clk)
    rst |=> ((result == '0) && !carry && zero));

endmodule

// File: tb/sim_opsel_alu.sv
`timescale 1ns/1ps
module sim_opsel_alu;

  localparam int WB = 8;
  localparam int WS = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    sel = 3'b000;
  logic [WB-1:0] a8 = '0, b8 = '0;
  logic [WS-1:0] a3 = '0, b3 = '0;
  logic [WB-1:0] r8;
  logic [WS-1:0] r3;
  logic          c8, z8, c3, z3;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // expected values of the outputs currently held in the registers
  longint e_r8, e_r3;
  bit     e_c8, e_z8, e_c3, e_z3;

  always #2.5 clk = ~clk;

  opsel_alu #(.WIDTH(WB)) u0 (
    .clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .op_sel(sel),
    .result(r8), .carry(c8), .zero(z8));

  opsel_alu #(.WIDTH(WS)) u1 (
    .clk(clk), .rst(rst), .op_a(a3), .op_b(b3), .op_sel(sel),
    .result(r3), .carry(c3), .zero(z3));

  function automatic void ref_alu(input int w, input longint a, input longint b,
                                  input int op, output longint res, output bit cy);
    longint mask = (longint'(1) << w) - 1;
    longint t;
    cy = 1'b0;
    case (op)
      0: begin t = a + b; res = t & mask; cy = ((t >> w) & 1) != 0; end
      1: begin res = (a - b) & mask; cy = (a < b); end
      2: res = a;
      3: res = b;
      4: res = a & b;
      5: res = a | b;
      6: res = a ^ b;
      default: res = (~a) & mask;
    endcase
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5, 6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " w8 result"}, longint'(r8), e_r8);
    check({tag, " w8 carry"},  longint'(c8), longint'(e_c8));
    check("R7 w8 zero",        longint'(z8), longint'(e_z8));
    check({tag, " w3 result"}, longint'(r3), e_r3);
    check({tag, " w3 carry"},  longint'(c3), longint'(e_c3));
    check("R7 w3 zero",        longint'(z3), longint'(e_z3));
  endtask

  function automatic void set_reset_exp();
    e_r8 = 0; e_c8 = 0; e_z8 = 1;
    e_r3 = 0; e_c3 = 0; e_z3 = 1;
  endfunction

  // Called at a falling edge: drive, confirm outputs hold (R8), capture, compare.
  task automatic step(input int op, input longint x8, input longint y8,
                      input longint x3, input longint y3);
    sel = op[2:0];
    a8 = x8[WB-1:0]; b8 = y8[WB-1:0];
    a3 = x3[WS-1:0]; b3 = y3[WS-1:0];
    #1;
    check("R8 w8 hold", longint'(r8), e_r8);
    check("R8 w3 hold", longint'(r3), e_r3);
    ref_alu(WB, x8 & 64'hFF, y8 & 64'hFF, op, e_r8, e_c8);
    e_z8 = (e_r8 == 0);
    ref_alu(WS, x3 & 64'h7, y3 & 64'h7, op, e_r3, e_c3);
    e_z3 = (e_r3 == 0);
    @(negedge clk);
    check_all(op_tag(op));
  endtask

  int unsigned lfsr = 32'h1234_5678;
  function automatic int unsigned next_rand(input int unsigned s);
    int unsigned v = s;
    v ^= v << 13; v ^= v >> 17; v ^= v << 5;
    return v;
  endfunction

  initial begin
    longint keep;
    set_reset_exp();
    repeat (3) @(negedge clk);
    // R9: state after reset edges
    check_all("R9");
    rst = 1'b0;

    // R1: exhaustive on the 3-bit copy, pseudo-random on the 8-bit copy
    for (int op = 0; op < 8; op++) begin
      for (int x = 0; x < 8; x++) begin
        for (int y = 0; y < 8; y++) begin
          lfsr = next_rand(lfsr);
          step(op, longint'(lfsr & 32'hFF), longint'((lfsr >> 8) & 32'hFF),
               longint'(x), longint'(y));
        end
      end
    end

    // 8-bit extremes for each code (R2, R3 carry/borrow edges, R7 zero results)
    for (int op = 0; op < 8; op++) begin
      step(op, 64'hFF, 64'h01, 7, 1);
      step(op, 64'h00, 64'h01, 0, 1);
      step(op, 64'h80, 64'h80, 4, 4);
      step(op, 64'h55, 64'hAA, 5, 2);
      step(op, 64'hFF, 64'hFF, 7, 7);
      step(op, 64'h00, 64'h00, 0, 0);
    end

    // R6: b has no effect under the inversion code
    step(7, 64'h3C, 64'h00, 3, 0);
    keep = longint'(r8);
    step(7, 64'h3C, 64'hFF, 3, 7);
    check("R6 b ignored", longint'(r8), keep);
    check("R6 b ignored carry", longint'(c8), 0);

    // R9: mid-run reset with non-zero inputs applied
    sel = 3'b000; a8 = 8'hF0; b8 = 8'h20; a3 = 3'd7; b3 = 3'd3;
    rst = 1'b1;
    @(negedge clk);
    set_reset_exp();
    check_all("R9");
    rst = 1'b0;
    step(0, 64'hF0, 64'h20, 7, 3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule